// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block holds a processor core in reset after power comes up. Once the power-on pulse ends, it runs up to three timeout stages in a fixed order: a power-up delay, an oscillator start-up count and a PLL lock wait. The configuration inputs decide which stages run. The core leaves reset only after the last enabled stage has expired and the synchronized master-clear input is high.

The timeout chain starts from the power-on event, not from the release of master-clear. If master-clear is still held low after every stage has expired, the core starts as soon as the synchronized master-clear goes high. A master-clear during execution puts the core back into reset but does not rerun the timers.

The block also keeps five reset-cause flags that software reads and can partly write. These flags record power-on, brown-out, watchdog timeout, power-down and reset-instruction events. A watchdog expiry during sleep is a wake-up: it updates the flags but resets nothing.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_i` or `bor_i` is high, the stage moves to code 0 on the next edge and `core_rst_o` is high. The stage codes are 0 idle-in-reset, 1 power-up delay, 2 oscillator start-up, 3 PLL lock and 4 running.
- R2: With `pwrt_en_i`=1, stage 1 begins on the first edge after the power-on pulse clears and lasts exactly PWRT_LEN cycles.
- R3: Stage 2 lasts exactly OST_LEN cycles and runs in every oscillator mode except RC. `osc_en_o` is high from the first cycle of stage 2 onward, while running, and in RC mode once running.
- R4: Stage 3 runs for exactly PLL_LEN cycles after stage 2, and only when `osc_mode_i`=2 (PLL). `osc_mode_i`=1 or 3 (crystal) goes from stage 2 straight to stage 4.
- R5: With `osc_mode_i`=0 (RC) and `pwrt_en_i`=0, the stage is 4 on the first edge after the pulse clears, so no timeout is applied.
- R6: If `mclr_n_i` stays low until after the chain reaches stage 4, `core_rst_o` stays high. It falls on the second edge after `mclr_n_i` rises.
- R7: When `mclr_n_i` falls during stage 4, `core_rst_o` rises on the second edge and the stage stays 4.
- R8: Flags are bit 4 reset-instruction, bit 3 watchdog, bit 2 power-down, bit 1 power-on and bit 0 brown-out. Reset and power-on load 5'b11100.
- R9: A software write with `sw_wr_i` loads bits 4, 1 and 0 from `sw_wdata_i`. Bits 3 and 2 ignore the write.
- R10: Sleep entry sets bit 3, clears bit 2 and raises `asleep_o`. A clear-watchdog event sets bits 3 and 2.
- R11: A watchdog expiry while asleep clears bit 3 and drops `asleep_o`. It does not assert `core_rst_o` and does not change the stage.
- R12: A watchdog expiry while awake clears bit 3, and a reset instruction clears bit 4. Each asserts `core_rst_o` for exactly one cycle with the stage staying 4.
- R13: A brown-out clears bit 0, sets bits 3 and 2, and restarts the chain from stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| por_i | input | 1 | Power-on pulse, high while active |
| bor_i | input | 1 | Brown-out event, high while active |
| mclr_n_i | input | 1 | Master-clear, active low, asynchronous |
| pwrt_en_i | input | 1 | Enables the power-up delay stage |
| osc_mode_i | input | 2 | Oscillator mode: 0 RC, 1 or 3 crystal, 2 PLL |
| sleep_i | input | 1 | Sleep entry pulse |
| wdt_i | input | 1 | Watchdog expiry pulse |
| clrwdt_i | input | 1 | Clear-watchdog pulse |
| rsti_i | input | 1 | Reset-instruction pulse |
| sw_wr_i | input | 1 | Software write strobe for the flags |
| sw_wdata_i | input | 5 | Software write data for the flags |
| core_rst_o | output | 1 | Holds the core in reset |
| osc_en_o | output | 1 | Oscillator enable |
| stage_o | output | 3 | Current stage code |
| asleep_o | output | 1 | Core is in sleep |
| flags_o | output | 5 | Reset-cause flags |

## Verification
A stage counter that is off by one moves the step on `stage_o` one cycle early or late. The bench checks every cycle of each window, so such an error shows on the first wrong cycle. A wrong stage skip shows on the first edge after the power-on pulse, either as an unexpected code or as `core_rst_o` falling too early. A wrong flag priority or write mask shows on `flags_o` one edge after the event. Errors in the master-clear path or the warm-reset path show on `core_rst_o` within two edges.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4
  } stage_e;

  localparam logic [1:0] OSC_RC  = 2'd0;
  localparam logic [1:0] OSC_PLL = 2'd2;

  localparam int FLAG_W = 5;
  localparam int FL_BOR = 0;
  localparam int FL_POR = 1;
  localparam int FL_PD  = 2;
  localparam int FL_TO  = 3;
  localparam int FL_RI  = 4;

  localparam logic [FLAG_W-1:0] FLAGS_RST = 5'b11100;
  localparam logic [FLAG_W-1:0] FLAGS_WRM = 5'b10011;

endpackage

// File: rtl/pwrup_seq_sync.sv
module pwrup_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n[0] = d_i;
    for (int i = 1; i < STAGES; i++) sh_n[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/pwrup_seq_chain.sv
module pwrup_seq_chain
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_LEN = 2048,
  parameter int OST_LEN  = 1024,
  parameter int PLL_LEN  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_rst_i,
  input  logic       pwrt_en_i,
  input  logic [1:0] osc_mode_i,
  output stage_e     stage_o,
  output logic       osc_en_o
);

  localparam int MAX_A  = (PWRT_LEN > OST_LEN) ? PWRT_LEN : OST_LEN;
  localparam int MAX_L  = (MAX_A > PLL_LEN) ? MAX_A : PLL_LEN;
  localparam int CNT_W  = (MAX_L > 2) ? $clog2(MAX_L) : 1;

  stage_e           stage_q, stage_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             upd_en;
  logic             is_rc, is_pll;

  assign is_rc  = (osc_mode_i == OSC_RC);
  assign is_pll = (osc_mode_i == OSC_PLL);

  function automatic logic [CNT_W-1:0] load_of(input stage_e s);
    case (s)
      ST_PWRT: load_of = CNT_W'(PWRT_LEN - 1);
      ST_OST:  load_of = CNT_W'(OST_LEN - 1);
      ST_PLL:  load_of = CNT_W'(PLL_LEN - 1);
      default: load_of = '0;
    endcase
  endfunction

  always_comb begin
    stage_n = stage_q;
    if (supply_rst_i) begin
      stage_n = ST_POR;
    end else begin
      case (stage_q)
        ST_POR:  stage_n = pwrt_en_i ? ST_PWRT : (is_rc ? ST_RUN : ST_OST);
        ST_PWRT: if (cnt_q == '0) stage_n = is_rc ? ST_RUN : ST_OST;
        ST_OST:  if (cnt_q == '0) stage_n = is_pll ? ST_PLL : ST_RUN;
        ST_PLL:  if (cnt_q == '0) stage_n = ST_RUN;
        default: stage_n = ST_RUN;
      endcase
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    if (supply_rst_i)              cnt_n = '0;
    else if (stage_n != stage_q)   cnt_n = load_of(stage_n);
    else if (cnt_q != '0)          cnt_n = cnt_q - 1'b1;
  end

  assign upd_en = supply_rst_i || (stage_n != stage_q) || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_POR;
      cnt_q   <= '0;
    end else if (upd_en) begin
      stage_q <= stage_n;
      cnt_q   <= cnt_n;
    end
  end

  assign stage_o  = stage_q;
  assign osc_en_o = (stage_q == ST_OST) || (stage_q == ST_PLL) || (stage_q == ST_RUN);

  a_r1_supply_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    supply_rst_i |=> (stage_q == ST_POR));

  a_r2_pwrt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_PWRT && cnt_q != '0 && !supply_rst_i) |=> (stage_q == ST_PWRT));

  a_r4_no_pll_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_OST && cnt_q == '0 && !supply_rst_i && !is_pll) |=> (stage_q == ST_RUN));

  a_r5_rc_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_POR && !supply_rst_i && !pwrt_en_i && is_rc) |=> (stage_q == ST_RUN));

endmodule

// File: rtl/pwrup_seq_evt.sv
module pwrup_seq_evt
  import pwrup_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              sleep_i,
  input  logic              wdt_i,
  input  logic              clrwdt_i,
  input  logic              rsti_i,
  input  logic              sw_wr_i,
  input  logic [FLAG_W-1:0] sw_wdata_i,
  input  logic              run_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              asleep_o,
  output logic              warm_o
);

  logic [FLAG_W-1:0] flags_q, flags_n, wr_val;
  logic              asleep_q, asleep_n;
  logic              warm_q, warm_n;
  logic              supply;

  assign supply = por_i | bor_i;
  assign wr_val = (flags_q & ~FLAGS_WRM) | (sw_wdata_i & FLAGS_WRM);

  always_comb begin
    flags_n = flags_q;

    if (por_i)        flags_n[FL_RI] = 1'b1;
    else if (rsti_i)  flags_n[FL_RI] = 1'b0;
    else if (sw_wr_i) flags_n[FL_RI] = wr_val[FL_RI];

    if (por_i)        flags_n[FL_POR] = 1'b0;
    else if (sw_wr_i) flags_n[FL_POR] = wr_val[FL_POR];

    if (supply)       flags_n[FL_BOR] = 1'b0;
    else if (sw_wr_i) flags_n[FL_BOR] = wr_val[FL_BOR];

    if (supply)                   flags_n[FL_TO] = 1'b1;
    else if (wdt_i)               flags_n[FL_TO] = 1'b0;
    else if (clrwdt_i || sleep_i) flags_n[FL_TO] = 1'b1;
    else if (sw_wr_i)             flags_n[FL_TO] = wr_val[FL_TO];

    if (supply)        flags_n[FL_PD] = 1'b1;
    else if (wdt_i)    flags_n[FL_PD] = flags_q[FL_PD];
    else if (sleep_i)  flags_n[FL_PD] = 1'b0;
    else if (clrwdt_i) flags_n[FL_PD] = 1'b1;
    else if (sw_wr_i)  flags_n[FL_PD] = wr_val[FL_PD];
  end

  always_comb begin
    asleep_n = asleep_q;
    if (supply || wdt_i) asleep_n = 1'b0;
    else if (sleep_i)    asleep_n = 1'b1;
  end

  assign warm_n = run_i && !supply && (rsti_i || (wdt_i && !asleep_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= FLAGS_RST;
      asleep_q <= 1'b0;
      warm_q   <= 1'b0;
    end else begin
      flags_q  <= flags_n;
      asleep_q <= asleep_n;
      warm_q   <= warm_n;
    end
  end

  assign flags_o  = flags_q;
  assign asleep_o = asleep_q;
  assign warm_o   = warm_q;

  a_r8_por_flags: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (flags_q == FLAGS_RST));

  a_r9_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && !supply && !wdt_i && !sleep_i && !clrwdt_i)
    |=> ($stable(flags_q[FL_TO]) && $stable(flags_q[FL_PD])));

  a_r11_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && wdt_i && !supply) |=> (!asleep_q && !warm_q));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int PWRT_LEN  = 2048,
  parameter int OST_LEN   = 1024,
  parameter int PLL_LEN   = 512,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       mclr_n_i,
  input  logic       pwrt_en_i,
  input  logic [1:0] osc_mode_i,
  input  logic       sleep_i,
  input  logic       wdt_i,
  input  logic       clrwdt_i,
  input  logic       rsti_i,
  input  logic       sw_wr_i,
  input  logic [4:0] sw_wdata_i,
  output logic       core_rst_o,
  output logic       osc_en_o,
  output logic [2:0] stage_o,
  output logic       asleep_o,
  output logic [4:0] flags_o
);

  stage_e stage;
  logic   mclr_s;
  logic   warm;
  logic   run;

  pwrup_seq_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mclr_n_i),
    .q_o   (mclr_s)
  );

  pwrup_seq_chain #(
    .PWRT_LEN (PWRT_LEN),
    .OST_LEN  (OST_LEN),
    .PLL_LEN  (PLL_LEN)
  ) u_chain (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_rst_i (por_i | bor_i),
    .pwrt_en_i    (pwrt_en_i),
    .osc_mode_i   (osc_mode_i),
    .stage_o      (stage),
    .osc_en_o     (osc_en_o)
  );

  assign run = (stage == ST_RUN);

  pwrup_seq_evt u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_i      (por_i),
    .bor_i      (bor_i),
    .sleep_i    (sleep_i),
    .wdt_i      (wdt_i),
    .clrwdt_i   (clrwdt_i),
    .rsti_i     (rsti_i),
    .sw_wr_i    (sw_wr_i),
    .sw_wdata_i (sw_wdata_i),
    .run_i      (run),
    .flags_o    (flags_o),
    .asleep_o   (asleep_o),
    .warm_o     (warm)
  );

  assign core_rst_o = !run || !mclr_s || warm;
  assign stage_o    = stage;

  a_r12_warm_no_rerun: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm) |-> run);

  a_r7_mclr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(mclr_s)) |-> core_rst_o);

  a_r6_release_path: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (run && mclr_s));

endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;

  localparam int P = 16;
  localparam int O = 64;
  localparam int L = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_i, bor_i, mclr_n_i, pwrt_en_i;
  logic [1:0] osc_mode_i;
  logic       sleep_i, wdt_i, clrwdt_i, rsti_i, sw_wr_i;
  logic [4:0] sw_wdata_i;
  logic       core_rst_o, osc_en_o, asleep_o;
  logic [2:0] stage_o;
  logic [4:0] flags_o;

  always #10 clk = ~clk;

  pwrup_seq #(.PWRT_LEN(P), .OST_LEN(O), .PLL_LEN(L)) i_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .bor_i(bor_i),
    .mclr_n_i(mclr_n_i), .pwrt_en_i(pwrt_en_i), .osc_mode_i(osc_mode_i),
    .sleep_i(sleep_i), .wdt_i(wdt_i), .clrwdt_i(clrwdt_i), .rsti_i(rsti_i),
    .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
    .core_rst_o(core_rst_o), .osc_en_o(osc_en_o), .stage_o(stage_o),
    .asleep_o(asleep_o), .flags_o(flags_o)
  );

  typedef struct {
    string      req;
    logic [2:0] stage;
    logic       rst;
    logic       osc;
    logic       slp;
    logic [4:0] flags;
  } exp_t;

  exp_t       sbq[$];
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  string      m_req;
  logic [2:0] m_stage;
  logic       m_rst, m_osc, m_slp;
  logic [4:0] m_flags;

  task automatic report(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      exp_t it;
      it = sbq.pop_front();
      report(it.req, "stage", int'(stage_o), int'(it.stage));
      report(it.req, "core_rst", int'(core_rst_o), int'(it.rst));
      report(it.req, "osc_en", int'(osc_en_o), int'(it.osc));
      report(it.req, "asleep", int'(asleep_o), int'(it.slp));
      report(it.req, "flags", int'(flags_o), int'(it.flags));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic tick();
    exp_t it;
    it.req = m_req; it.stage = m_stage; it.rst = m_rst;
    it.osc = m_osc; it.slp = m_slp; it.flags = m_flags;
    sbq.push_back(it);
    step();
  endtask

  task automatic window(input string req, input logic [2:0] st, input int len);
    m_req = req; m_stage = st;
    m_osc = (st >= 3'd2);
    for (int i = 0; i < len; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; por_i = 1'b1; bor_i = 1'b0; mclr_n_i = 1'b1;
    pwrt_en_i = 1'b1; osc_mode_i = 2'd2; sleep_i = 1'b0; wdt_i = 1'b0;
    clrwdt_i = 1'b0; rsti_i = 1'b0; sw_wr_i = 1'b0; sw_wdata_i = '0;
    m_stage = 3'd0; m_rst = 1'b1; m_osc = 1'b0; m_slp = 1'b0; m_flags = 5'b11100;
    repeat (3) step();
    rst_n = 1'b1;

    // R1 R8: reset state held while power-on is high
    m_req = "R1/R8 reset state";
    repeat (3) tick();

    // R2 R3 R4: PLL mode with power-up delay: all three stages
    por_i = 1'b0;
    window("R2 power-up delay", 3'd1, P);
    window("R3 oscillator start-up", 3'd2, O);
    window("R4 PLL lock", 3'd3, L);
    m_rst = 1'b0;
    window("R4 running after PLL", 3'd4, 2);

    // R4: crystal mode, no power-up delay: no PLL stage
    por_i = 1'b1; osc_mode_i = 2'd1; pwrt_en_i = 1'b0; m_rst = 1'b1;
    window("R1 idle in power-on", 3'd0, 2);
    por_i = 1'b0;
    window("R3 start-up only", 3'd2, O);
    m_rst = 1'b0;
    window("R4 crystal skips PLL", 3'd4, 2);

    // R5: RC mode without power-up delay
    por_i = 1'b1; osc_mode_i = 2'd0; m_rst = 1'b1;
    window("R1 idle RC", 3'd0, 2);
    por_i = 1'b0; m_rst = 1'b0;
    window("R5 RC no timeout", 3'd4, 2);

    // R9: software write, bits 3 and 2 read-only
    sw_wr_i = 1'b1; sw_wdata_i = 5'b10011;
    m_flags = 5'b11111; m_req = "R9 write mask";
    tick();
    sw_wr_i = 1'b0; sw_wdata_i = '0;

    // R10: sleep entry
    sleep_i = 1'b1; m_flags = 5'b11011; m_slp = 1'b1; m_req = "R10 sleep entry";
    tick();
    sleep_i = 1'b0;

    // R11: watchdog during sleep is a wake-up
    wdt_i = 1'b1; m_flags = 5'b10011; m_slp = 1'b0; m_req = "R11 wake no reset";
    tick();
    wdt_i = 1'b0;
    tick();

    // R10: clear-watchdog
    clrwdt_i = 1'b1; m_flags = 5'b11111; m_req = "R10 clear watchdog";
    tick();
    clrwdt_i = 1'b0;

    // R12: watchdog while awake
    wdt_i = 1'b1; m_flags = 5'b10111; m_rst = 1'b1; m_req = "R12 watchdog reset";
    tick();
    wdt_i = 1'b0; m_rst = 1'b0;
    tick(); tick();

    // R12: reset instruction
    rsti_i = 1'b1; m_flags = 5'b00111; m_rst = 1'b1; m_req = "R12 reset instruction";
    tick();
    rsti_i = 1'b0; m_rst = 1'b0;
    tick();

    // R13: brown-out restarts chain
    bor_i = 1'b1; m_flags = 5'b01110; m_rst = 1'b1;
    window("R13 brown-out", 3'd0, 1);
    bor_i = 1'b0; m_rst = 1'b0;
    window("R13 brown-out restart", 3'd4, 2);

    // R6: master-clear held low beyond the chain
    mclr_n_i = 1'b0; por_i = 1'b1; pwrt_en_i = 1'b1;
    m_rst = 1'b1; m_flags = 5'b11100;
    window("R8 power-on flags", 3'd0, 3);
    por_i = 1'b0;
    window("R6 delay under master-clear", 3'd1, P);
    window("R6 held by master-clear", 3'd4, 4);
    mclr_n_i = 1'b1;
    window("R6 first sync edge", 3'd4, 1);
    m_rst = 1'b0;
    window("R6 released", 3'd4, 2);

    // R7: master-clear during running
    mclr_n_i = 1'b0;
    window("R7 before sync", 3'd4, 1);
    m_rst = 1'b1;
    window("R7 reset no rerun", 3'd4, 3);
    mclr_n_i = 1'b1;
    window("R7 release sync", 3'd4, 1);
    m_rst = 1'b0;
    window("R7 running again", 3'd4, 2);

    step();
    finish_run();
  end

endmodule